// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

This block is a fixed-point multiplier that sits on a microcontroller's register bus. Software picks an operation and a data type in an 8-bit control register, then writes one or two 16-bit operands. Once the configured number of operands has arrived, the block forms the 16x16 product and combines it with a 48-bit accumulator. It can store the product, add it, subtract it, or store its negation. The accumulator is read back as three 16-bit words.

The block handles unsigned and signed operands. A square mode takes one operand and uses it as both multiplier inputs. An overflow flag records any accumulate or subtract whose exact result does not fit in 48 bits. Each computation finishes in the same clock edge that captures the last operand, so operand writes can follow one another on every cycle.

The bus is a plain register port: a write strobe with an address and data, and a separate read address with combinational read data. Every write is accepted in the cycle it is presented. There is no back-pressure.

Top module: `mac_unit`

## Requirements
- R1: The register map is: address 0 control, address 1 operand A, address 2 operand B, and addresses 3, 4 and 5 the accumulator bits 15:0, 31:16 and 47:32. Operation code 0 writes the 48-bit product into the accumulator. The product is zero-extended when control bit 0 is 0 (unsigned) and sign-extended when it is 1 (signed).
- R2: Operation code 1 (control bits 2:1) adds the extended product to the accumulator.
- R3: Operation code 2 subtracts the extended product from the accumulator.
- R4: Operation code 3 writes the negated product in signed mode. In unsigned mode it behaves exactly as code 0.
- R5: When control bits 3 and 4 are both 0, the operation fires on the second operand write after the last control write. When control bit 3 is 1, every operand write fires, using the other operand's stored value. A control write restarts the operand count.
- R6: When control bit 4 (square) is 1, a write to either operand loads both operands with that value and fires.
- R7: The accumulator holds the new result in the cycle right after the last operand write. Operand writes on consecutive cycles each take effect with no lost or delayed operation.
- R8: Control bit 6 reads as the overflow flag. The flag is set by a code 1 or code 2 result that falls outside the 48-bit range: for unsigned data, a carry or a borrow; for signed data, a two's-complement overflow. The flag stays set until a control write with bit 6 at 0.
- R9: Operation codes 0 and 3 never change the overflow flag.
- R10: A control write with bit 7 set clears both operands, the accumulator and the overflow flag. Bit 7 always reads as 0.
- R11: When control bit 5 is 1, writes to addresses 3 to 5 load that accumulator word. When bit 5 is 0, such writes have no effect.
- R12: After reset, the control register, both operands and the accumulator all read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Combinational read data |

## Verification
The assertions assume that at most one register is written per cycle, because the port carries a single address. They also assume that writes to addresses 6 and 7 are never made. The bench drives only one write strobe at a time and uses only addresses 0 to 5. The stimulus covers operand writes on consecutive cycles, and those never coincide with a control write, so the clear, fire and word-load priorities are each exercised separately.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    OP_MUL = 2'd0,
    OP_ADD = 2'd1,
    OP_SUB = 2'd2,
    OP_NEG = 2'd3
  } mac_op_e;

  // bit 7 .. bit 0
  typedef struct packed {
    logic    clear;
    logic    ovf;
    logic    acc_wr;
    logic    square;
    logic    one_op;
    mac_op_e op;
    logic    signed_mode;
  } ctrl_t;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_OPA  = 3'd1;
  localparam logic [ADDR_W-1:0] A_OPB  = 3'd2;
  localparam logic [ADDR_W-1:0] A_ACC0 = 3'd3;

endpackage

// File: rtl/mac_ctrl_reg.sv
module mac_ctrl_reg
  import mac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       ovf_set,
  output ctrl_t      cfg,
  output logic       clr
);

  ctrl_t cfg_q;

  // A clear request only acts in the write cycle; it is never stored.
  assign clr = wr & wdata[7];
  assign cfg = cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr) begin
      cfg_q.signed_mode <= wdata[0];
      cfg_q.op          <= mac_op_e'(wdata[2:1]);
      cfg_q.one_op      <= wdata[3];
      cfg_q.square      <= wdata[4];
      cfg_q.acc_wr      <= wdata[5];
      // writing 1 keeps the flag, writing 0 or clearing drops it
      cfg_q.ovf         <= wdata[6] & cfg_q.ovf & ~wdata[7];
      cfg_q.clear       <= 1'b0;
    end else if (ovf_set) begin
      cfg_q.ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/mac_operand_seq.sv
module mac_operand_seq #(
  parameter int OPW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           one_op,
  input  logic           square,
  input  logic           ctrl_wr,
  input  logic           clr,
  input  logic           opa_wr,
  input  logic           opb_wr,
  input  logic [OPW-1:0] wdata,
  output logic [OPW-1:0] opa,
  output logic [OPW-1:0] opb,
  output logic [OPW-1:0] opa_nx,
  output logic [OPW-1:0] opb_nx,
  output logic           fire
);

  logic half_q;
  logic any_wr;
  logic single;

  assign any_wr = opa_wr | opb_wr;
  assign single = one_op | square;
  assign fire   = any_wr & (single | half_q);

  // Operand values as they will be after this cycle's write.
  always_comb begin
    opa_nx = opa;
    opb_nx = opb;
    if (opa_wr || (opb_wr && square)) opa_nx = wdata;
    if (opb_wr || (opa_wr && square)) opb_nx = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa    <= '0;
      opb    <= '0;
      half_q <= 1'b0;
    end else begin
      if (clr) begin
        opa <= '0;
        opb <= '0;
      end else begin
        opa <= opa_nx;
        opb <= opb_nx;
      end
      if (ctrl_wr) half_q <= 1'b0;
      else if (any_wr) half_q <= ~fire;
    end
  end

endmodule

// File: rtl/mac_arith.sv
module mac_arith
  import mac_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int ACCW = 48
) (
  input  logic [OPW-1:0]  a,
  input  logic [OPW-1:0]  b,
  input  logic            signed_mode,
  input  mac_op_e         op,
  input  logic [ACCW-1:0] acc,
  output logic [ACCW-1:0] acc_nx,
  output logic            ovf
);

  localparam int PW  = 2 * OPW + 2;
  localparam int EXT = ACCW + 1 - PW;

  logic [OPW:0]         ax, bx;
  logic signed [PW-1:0] prod;
  logic [ACCW:0]        pext, accx, sum;

  always_comb begin
    ax   = {signed_mode & a[OPW-1], a};
    bx   = {signed_mode & b[OPW-1], b};
    prod = $signed(ax) * $signed(bx);
    pext = {{EXT{prod[PW-1]}}, prod};
    accx = {signed_mode & acc[ACCW-1], acc};
    ovf  = 1'b0;
    unique case (op)
      OP_MUL: sum = pext;
      OP_NEG: sum = signed_mode ? (ACCW+1)'(-pext) : pext;
      OP_ADD: sum = accx + pext;
      OP_SUB: sum = accx - pext;
      default: sum = pext;
    endcase
    if (op == OP_ADD || op == OP_SUB)
      ovf = signed_mode ? (sum[ACCW] ^ sum[ACCW-1]) : sum[ACCW];
    acc_nx = sum[ACCW-1:0];
  end

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int ACCW = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [OPW-1:0]    wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [OPW-1:0]    rd_data
);

  localparam int NWORD = ACCW / OPW;

  logic            ctrl_wr, opa_wr, opb_wr;
  ctrl_t           cfg;
  logic            clr, fire, ovf_nx;
  logic [OPW-1:0]  opa, opb, opa_nx, opb_nx;
  logic [ACCW-1:0] acc, acc_nx;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign opa_wr  = wr_en && (wr_addr == A_OPA);
  assign opb_wr  = wr_en && (wr_addr == A_OPB);

  mac_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (ctrl_wr),
    .wdata   (wr_data[7:0]),
    .ovf_set (fire & ovf_nx),
    .cfg     (cfg),
    .clr     (clr)
  );

  mac_operand_seq #(.OPW(OPW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .one_op  (cfg.one_op),
    .square  (cfg.square),
    .ctrl_wr (ctrl_wr),
    .clr     (clr),
    .opa_wr  (opa_wr),
    .opb_wr  (opb_wr),
    .wdata   (wr_data),
    .opa     (opa),
    .opb     (opb),
    .opa_nx  (opa_nx),
    .opb_nx  (opb_nx),
    .fire    (fire)
  );

  mac_arith #(.OPW(OPW), .ACCW(ACCW)) u_arith (
    .a           (opa_nx),
    .b           (opb_nx),
    .signed_mode (cfg.signed_mode),
    .op          (cfg.op),
    .acc         (acc),
    .acc_nx      (acc_nx),
    .ovf         (ovf_nx)
  );

  // Accumulator: clear beats a computation, which beats a word load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (clr) begin
      acc <= '0;
    end else if (fire) begin
      acc <= acc_nx;
    end else if (wr_en && cfg.acc_wr) begin
      for (int w = 0; w < NWORD; w++) begin
        if (wr_addr == ADDR_W'(int'(A_ACC0) + w))
          acc[w*OPW +: OPW] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CTRL) rd_data = OPW'(cfg);
    if (rd_addr == A_OPA)  rd_data = opa;
    if (rd_addr == A_OPB)  rd_data = opb;
    for (int w = 0; w < NWORD; w++) begin
      if (rd_addr == ADDR_W'(int'(A_ACC0) + w))
        rd_data = acc[w*OPW +: OPW];
    end
  end

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk
  import mac_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int ACCW = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              clr_bit,
  input logic              fire,
  input logic              square,
  input logic              acc_wr,
  input mac_op_e           op,
  input logic              ovf,
  input logic [OPW-1:0]    opa,
  input logic [OPW-1:0]    opb,
  input logic [ACCW-1:0]   acc
);

  logic ctrl_hit, acc_hit;
  assign ctrl_hit = wr_en && (wr_addr == A_CTRL);
  assign acc_hit  = wr_en && acc_wr && (wr_addr >= A_ACC0) && (wr_addr <= 3'd5);

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ctrl_hit) |=> ovf); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (op == OP_MUL || op == OP_NEG)) |=> (ovf == $past(ovf))); // R9

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_hit && clr_bit) |=> (acc == '0 && opa == '0 && opb == '0 && !ovf)); // R10

  AST_SQUARE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && square) |=> (opa == opb)); // R6

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !acc_hit && !(ctrl_hit && clr_bit)) |=> $stable(acc)); // R11

endmodule

bind mac_unit mac_unit_chk #(.OPW(OPW), .ACCW(ACCW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .clr_bit (wr_data[7]),
  .fire    (fire),
  .square  (cfg.square),
  .acc_wr  (cfg.acc_wr),
  .op      (cfg.op),
  .ovf     (cfg.ovf),
  .opa     (opa),
  .opb     (opb),
  .acc     (acc)
);

// File: tb/tb_mac_unit.sv
module tb_mac_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  mac_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // {ctrl, a, b, expected accumulator}; square/one-operand rows write only a
  localparam logic [87:0] VEC [0:9] = '{
    {8'h40, 16'h0003, 16'h0005, 48'h0000_0000_000F},
    {8'h42, 16'hFFFF, 16'hFFFF, 48'h0000_FFFE_0010},
    {8'h44, 16'h0002, 16'h0008, 48'h0000_FFFE_0000},
    {8'h41, 16'hFFFD, 16'h0007, 48'hFFFF_FFFF_FFEB},
    {8'h43, 16'h8000, 16'h8000, 48'h0000_3FFF_FFEB},
    {8'h45, 16'h0004, 16'hFFFF, 48'h0000_3FFF_FFEF},
    {8'h47, 16'h0005, 16'h0006, 48'hFFFF_FFFF_FFE2},
    {8'h50, 16'h0100, 16'h0000, 48'h0000_0001_0000},
    {8'h48, 16'h0003, 16'h0000, 48'h0000_0000_0300},
    {8'h53, 16'hFFFF, 16'h0000, 48'h0000_0000_0301}
  };

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] ad, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ad; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] ad, output logic [15:0] v);
    rd_addr = ad;
    #1 v = rd_data;
  endtask

  task automatic rd_acc(output logic [47:0] v);
    logic [15:0] w0, w1, w2;
    rd(3'd3, w0); rd(3'd4, w1); rd(3'd5, w2);
    v = {w2, w1, w0};
  endtask

  function automatic string tag_of(input logic [7:0] c);
    if (c[4]) return "R6";
    if (c[3]) return "R5";
    case (c[2:1])
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [47:0] v;
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    rd(3'd0, r); check("R12 ctrl", 48'(r), 48'h0);
    rd(3'd1, r); check("R12 opa", 48'(r), 48'h0);
    rd(3'd2, r); check("R12 opb", 48'(r), 48'h0);
    rd_acc(v);   check("R12 acc", v, 48'h0);

    // vector table; each result read the cycle after the last write (R7)
    for (int i = 0; i < 10; i++) begin
      logic [7:0] c;
      c = VEC[i][87:80];
      wr(3'd0, 16'(c));
      wr(3'd1, VEC[i][79:64]);
      if (!(c[3] | c[4])) wr(3'd2, VEC[i][63:48]);
      rd_acc(v);
      check(tag_of(c), v, VEC[i][47:0]);
      rd(3'd0, r);
      check("R9 no ovf", 48'(r[6]), 48'h0);
    end

    // R5: control write restarts the operand count
    wr(3'd0, 16'h0040);
    wr(3'd1, 16'h0007);
    wr(3'd0, 16'h0040);
    wr(3'd1, 16'h0009);
    rd_acc(v); check("R5 no fire on first", v, 48'h0000_0000_0301);
    wr(3'd2, 16'h0002);
    rd_acc(v); check("R5 fire on second", v, 48'h0000_0000_0012);

    // R7 back-to-back writes, unsigned accumulate
    wr(3'd0, 16'h0080);
    wr(3'd0, 16'h0042);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 16'd2;
    @(negedge clk); wr_addr = 3'd2; wr_data = 16'd3;
    @(negedge clk); wr_addr = 3'd1; wr_data = 16'd4;
    @(negedge clk); wr_addr = 3'd2; wr_data = 16'd5;
    @(negedge clk); wr_en = 1'b0;
    rd_acc(v); check("R7 back-to-back", v, 48'd26);

    // R11 word load, then R8 unsigned carry
    wr(3'd0, 16'h0060);
    wr(3'd3, 16'hFFFF); wr(3'd4, 16'hFFFF); wr(3'd5, 16'hFFFF);
    rd_acc(v); check("R11 word load", v, 48'hFFFF_FFFF_FFFF);
    wr(3'd0, 16'h0062);
    wr(3'd1, 16'h0001); wr(3'd2, 16'h0001);
    rd_acc(v); check("R8 carry wrap", v, 48'h0);
    rd(3'd0, r); check("R8 carry flag", 48'(r[6]), 48'h1);

    // R9/R8 sticky across a multiply
    wr(3'd0, 16'h0040);
    wr(3'd1, 16'h0002); wr(3'd2, 16'h0003);
    rd_acc(v); check("R1 mul", v, 48'd6);
    rd(3'd0, r); check("R8 sticky", 48'(r[6]), 48'h1);
    wr(3'd0, 16'h0000);
    rd(3'd0, r); check("R8 cleared", 48'(r[6]), 48'h0);

    // R8 signed subtract overflow
    wr(3'd0, 16'h0020);
    wr(3'd3, 16'h0000); wr(3'd4, 16'h0000); wr(3'd5, 16'h8000);
    wr(3'd0, 16'h0065);
    wr(3'd1, 16'h0001); wr(3'd2, 16'h0001);
    rd_acc(v); check("R8 signed sub", v, 48'h7FFF_FFFF_FFFF);
    rd(3'd0, r); check("R8 signed flag", 48'(r[6]), 48'h1);

    // R8 unsigned borrow
    wr(3'd0, 16'h0024);
    wr(3'd3, 16'h0000); wr(3'd4, 16'h0000); wr(3'd5, 16'h0000);
    wr(3'd1, 16'h0001); wr(3'd2, 16'h0001);
    rd_acc(v); check("R3 borrow wrap", v, 48'hFFFF_FFFF_FFFF);
    rd(3'd0, r); check("R8 borrow flag", 48'(r[6]), 48'h1);

    // R11 word write ignored when disabled
    wr(3'd0, 16'h0040);
    wr(3'd3, 16'h1234);
    rd_acc(v); check("R11 ignored", v, 48'hFFFF_FFFF_FFFF);

    // R10 clear
    wr(3'd0, 16'h00C0);
    rd_acc(v);   check("R10 acc", v, 48'h0);
    rd(3'd1, r); check("R10 opa", 48'(r), 48'h0);
    rd(3'd2, r); check("R10 opb", 48'(r), 48'h0);
    rd(3'd0, r); check("R10 ctrl bits", 48'(r[7:6]), 48'h0);

    // R4 unsigned negate acts as multiply
    wr(3'd0, 16'h0046);
    wr(3'd1, 16'h0002); wr(3'd2, 16'h0003);
    rd_acc(v); check("R4 unsigned neg", v, 48'd6);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule